// File: doc/BRIEF.md
# Packed SIMD Float-to-Integer Converter

This block turns each floating-point lane of a packed 64-bit operand into an integer of the same width, written back into the same lane position. A size code chooses four 16-bit half-precision lanes or two 32-bit single-precision lanes. A select bit chooses a signed or an unsigned result, and a 2-bit field chooses the rounding mode. The nominal mode is round to nearest. The conversion always runs under one fixed control setting: subnormal inputs are flushed to zero, out-of-range values saturate, and each lane reports its own invalid and inexact flags.

A quad flag asks for a 128-bit operand, which is sent as two 64-bit beats: the low half first, then the high half, with a last marker on the second beat. Encodings that are not allowed give a single beat flagged undefined, and that beat carries no result. An encoding is not allowed when the size code is reserved, when 16-bit lanes are disabled by parameter, or when quad mode is used with an odd register index.

Both the operand side and the result side are valid/ready streams. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when no high half is waiting and the output register is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `simd_f2i_conv`

## Requirements
- R1: Size code 01 selects four 16-bit lanes, with lane i at bits [16i+15:16i]. Size code 10 selects two 32-bit lanes, with lane i at bits [32i+31:32i]. Each result lane is an integer of the same width as its source lane.
- R2: Size codes 00 and 11 are undefined, and so is code 01 when HALF_EN is 0. An undefined operand gives one beat with out_undef=1, out_last=1, out_data=0 and both flag vectors 0.
- R3: in_unsigned=1 gives an unsigned result and 0 gives a two's-complement signed result. A NaN gives 0 with the lane's invalid flag set. Infinities and values outside the integer range saturate to the minimum or maximum integer with invalid set. A lane whose invalid flag is set never has its inexact flag set.
- R4: The rounding field decodes as follows: 00 is nearest with ties away from zero, 01 is nearest with ties to even, 10 is toward +infinity, and 11 is toward -infinity.
- R5: A lane's inexact flag is set whenever rounding discards nonzero fraction bits and the lane is not invalid.
- R6: Zero and subnormal inputs of either sign give 0 with no flags.
- R7: In an unsigned conversion, a negative input that rounds to 0 gives 0 with only the inexact flag as applicable. A negative input that rounds to a nonzero value gives 0 with invalid set.
- R8: With in_quad=1, bits [63:0] are converted first and sent with out_last=0. Bits [127:64] follow as the next beat with out_last=1. With in_quad=0, the single beat has out_last=1.
- R9: With in_quad=1, a 1 on in_src_lsb or in_dst_lsb (an odd register index) makes the operand undefined, as in R2.
- R10: A beat appears on the output in the cycle after its operand is accepted. The output holds stable while out_ready is low. in_ready stays low while a high half is waiting.
- R11: For 32-bit lanes, flag bits 0 and 1 belong to lanes 0 and 1, and flag bits 2 and 3 are 0. For 16-bit lanes, flag bit i belongs to lane i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand can be taken |
| in_data | input | 128 | Packed operand; high half used only in quad mode |
| in_size | input | 2 | Lane size code |
| in_unsigned | input | 1 | 1 = unsigned result, 0 = signed |
| in_rmode | input | 2 | Rounding mode |
| in_quad | input | 1 | Process 128 bits as two beats |
| in_src_lsb | input | 1 | Least significant bit of the source register index |
| in_dst_lsb | input | 1 | Least significant bit of the destination register index |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 64 | Packed integer result |
| out_last | output | 1 | Final beat of the operand |
| out_undef | output | 1 | Undefined encoding; no result |
| out_invalid | output | 4 | Per-lane invalid flags |
| out_inexact | output | 4 | Per-lane inexact flags |

## Verification
The bench drives exact halves such as 1.5, 2.5 and -2.5 through all four rounding modes. A design that mixed up the tie rules or the directed modes would be one off in some lane. It also drives the range edges: 65504, 2^31, -2^31 and 2^32, together with infinities, NaN, subnormals, -0 and small negatives under unsigned conversion. A wrong saturation bound or a misplaced flag shows up there as a wrapped value or a stray invalid or inexact bit. Quad operands are sent with back-pressure held for several cycles, and then with odd register indices. These tests expose halves sent in the wrong order, a missing last marker, a second operand accepted too early, or an odd index that still gets converted.

// File: rtl/simd_f2i_pkg.sv
package simd_f2i_pkg;
  localparam int WORD_W  = 64;
  localparam int HALF_LN = WORD_W / 16;
  localparam int SNGL_LN = WORD_W / 32;
  localparam int FLAG_W  = HALF_LN;

  typedef enum logic [1:0] {
    RM_NEAR_AWAY = 2'b00,
    RM_NEAR_EVEN = 2'b01,
    RM_UP        = 2'b10,
    RM_DOWN      = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    SZ_RSV0 = 2'b00,
    SZ_H16  = 2'b01,
    SZ_S32  = 2'b10,
    SZ_RSV3 = 2'b11
  } esize_e;
endpackage

// File: rtl/simd_f2i_lane.sv
module simd_f2i_lane
  import simd_f2i_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int INT_W = 1 + EXP_W + MAN_W
) (
  input  logic [INT_W-1:0] op_i,
  input  logic             uns_i,
  input  rmode_e           rm_i,
  output logic [INT_W-1:0] res_o,
  output logic             inv_o,
  output logic             inx_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int FW   = MAN_W + 2;       // fraction bits kept
  localparam int XW   = FW + INT_W;      // fixed-point width
  localparam int UEW  = EXP_W + 2;       // signed exponent width
  localparam logic [INT_W:0] S_MAX = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0] N_MAX = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W:0] U_MAX = {1'b0, {INT_W{1'b1}}};

  logic               sgn;
  logic [EXP_W-1:0]   ex;
  logic [MAN_W-1:0]   mn;
  logic signed [UEW-1:0] ue, sh;
  logic               is_nan, is_inf, is_zero, big, tiny;
  logic [XW-1:0]      fx;
  logic [INT_W-1:0]   ipart;
  logic               rb, st, lsb, inc, lost;
  logic [INT_W:0]     mag, neg;

  // Alignment: value placed on a grid of 2^-FW, integer part above it.
  always_comb begin
    {sgn, ex, mn} = op_i;
    is_nan  = (&ex) & (|mn);
    is_inf  = (&ex) & ~(|mn);
    is_zero = ~(|ex);
    ue      = $signed({2'b00, ex}) - $signed(UEW'(BIAS));
    sh      = ue + $signed(UEW'(2));
    big     = (ue >= $signed(UEW'(INT_W)));
    tiny    = sh[UEW-1];
    fx      = XW'({1'b1, mn}) << sh[UEW-2:0];
    if (tiny) begin
      ipart = '0;
      rb    = 1'b0;
      st    = 1'b1;
      lsb   = 1'b0;
    end else begin
      ipart = fx[XW-1:FW];
      rb    = fx[FW-1];
      st    = |fx[FW-2:0];
      lsb   = fx[FW];
    end
  end

  // Rounding increment per mode.
  always_comb begin
    lost = rb | st;
    unique case (rm_i)
      RM_NEAR_AWAY: inc = rb;
      RM_NEAR_EVEN: inc = rb & (st | lsb);
      RM_UP:        inc = ~sgn & lost;
      RM_DOWN:      inc = sgn & lost;
      default:      inc = 1'b0;
    endcase
    mag = {1'b0, ipart} + (INT_W+1)'(inc);
    neg = -mag;
  end

  // Range check, saturation and flags.
  always_comb begin
    res_o = '0;
    inv_o = 1'b0;
    inx_o = 1'b0;
    if (is_nan) begin
      inv_o = 1'b1;
    end else if (is_zero) begin
      res_o = '0;
    end else if (is_inf || big) begin
      inv_o = 1'b1;
      if (uns_i) res_o = sgn ? '0 : {INT_W{1'b1}};
      else       res_o = sgn ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    end else if (uns_i) begin
      if (sgn) begin
        if (mag != '0) inv_o = 1'b1;
        else           inx_o = lost;
      end else if (mag > U_MAX) begin
        res_o = {INT_W{1'b1}};
        inv_o = 1'b1;
      end else begin
        res_o = mag[INT_W-1:0];
        inx_o = lost;
      end
    end else begin
      if (sgn) begin
        if (mag > N_MAX) begin
          res_o = {1'b1, {(INT_W-1){1'b0}}};
          inv_o = 1'b1;
        end else begin
          res_o = neg[INT_W-1:0];
          inx_o = lost;
        end
      end else if (mag > S_MAX) begin
        res_o = {1'b0, {(INT_W-1){1'b1}}};
        inv_o = 1'b1;
      end else begin
        res_o = mag[INT_W-1:0];
        inx_o = lost;
      end
    end
  end

  always_comb begin
    p_flag_excl_r3: assert (!(inv_o && inx_o));
    p_uns_neg_r7:   assert (!(uns_i && sgn && (res_o != '0)));
    p_zero_in_r6:   assert (!(is_zero && (inv_o || inx_o || res_o != '0)));
  end
endmodule

// File: rtl/simd_f2i_word.sv
module simd_f2i_word
  import simd_f2i_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic [WORD_W-1:0] op_i,
  input  esize_e            size_i,
  input  logic              uns_i,
  input  rmode_e            rm_i,
  output logic [WORD_W-1:0] res_o,
  output logic [FLAG_W-1:0] inv_o,
  output logic [FLAG_W-1:0] inx_o
);
  logic [WORD_W-1:0]  h_res, s_res;
  logic [HALF_LN-1:0] h_inv, h_inx;
  logic [SNGL_LN-1:0] s_inv, s_inx;

  generate
    if (HALF_EN) begin : g_half
      for (genvar g = 0; g < HALF_LN; g++) begin : g_lane
        simd_f2i_lane #(.EXP_W(5), .MAN_W(10)) u_lane (
          .op_i  (op_i[16*g +: 16]),
          .uns_i (uns_i),
          .rm_i  (rm_i),
          .res_o (h_res[16*g +: 16]),
          .inv_o (h_inv[g]),
          .inx_o (h_inx[g])
        );
      end
    end else begin : g_nohalf
      assign h_res = '0;
      assign h_inv = '0;
      assign h_inx = '0;
    end

    for (genvar g = 0; g < SNGL_LN; g++) begin : g_sngl
      simd_f2i_lane #(.EXP_W(8), .MAN_W(23)) u_lane (
        .op_i  (op_i[32*g +: 32]),
        .uns_i (uns_i),
        .rm_i  (rm_i),
        .res_o (s_res[32*g +: 32]),
        .inv_o (s_inv[g]),
        .inx_o (s_inx[g])
      );
    end
  endgenerate

  always_comb begin
    if (size_i == SZ_H16) begin
      res_o = h_res;
      inv_o = h_inv;
      inx_o = h_inx;
    end else begin
      res_o = s_res;
      inv_o = FLAG_W'(s_inv);
      inx_o = FLAG_W'(s_inx);
    end
  end
endmodule

// File: rtl/simd_f2i_decode.sv
module simd_f2i_decode
  import simd_f2i_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  esize_e size_i,
  input  logic   quad_i,
  input  logic   src_lsb_i,
  input  logic   dst_lsb_i,
  output logic   undef_o
);
  logic bad_size, bad_align;

  always_comb begin
    bad_size  = (size_i == SZ_RSV0) || (size_i == SZ_RSV3) ||
                ((size_i == SZ_H16) && !HALF_EN);
    bad_align = quad_i && (src_lsb_i || dst_lsb_i);
    undef_o   = bad_size || bad_align;
  end
endmodule

// File: rtl/simd_f2i_conv.sv
module simd_f2i_conv
  import simd_f2i_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [127:0]  in_data,
  input  logic [1:0]    in_size,
  input  logic          in_unsigned,
  input  logic [1:0]    in_rmode,
  input  logic          in_quad,
  input  logic          in_src_lsb,
  input  logic          in_dst_lsb,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [63:0]   out_data,
  output logic          out_last,
  output logic          out_undef,
  output logic [3:0]    out_invalid,
  output logic [3:0]    out_inexact
);
  // Second-half holding state for quad operands.
  logic              pend_q;
  logic [WORD_W-1:0] pend_op_q;
  esize_e            pend_size_q;
  logic              pend_uns_q;
  rmode_e            pend_rm_q;

  logic              slot_free, take, undef;
  logic [WORD_W-1:0] cv_op, cv_res;
  esize_e            cv_size;
  logic              cv_uns;
  rmode_e            cv_rm;
  logic [FLAG_W-1:0] cv_inv, cv_inx;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = !pend_q && slot_free;
  assign take      = in_valid && in_ready;

  always_comb begin
    cv_op   = pend_q ? pend_op_q   : in_data[WORD_W-1:0];
    cv_size = pend_q ? pend_size_q : esize_e'(in_size);
    cv_uns  = pend_q ? pend_uns_q  : in_unsigned;
    cv_rm   = pend_q ? pend_rm_q   : rmode_e'(in_rmode);
  end

  simd_f2i_decode #(.HALF_EN(HALF_EN)) u_dec (
    .size_i    (esize_e'(in_size)),
    .quad_i    (in_quad),
    .src_lsb_i (in_src_lsb),
    .dst_lsb_i (in_dst_lsb),
    .undef_o   (undef)
  );

  simd_f2i_word #(.HALF_EN(HALF_EN)) u_word (
    .op_i   (cv_op),
    .size_i (cv_size),
    .uns_i  (cv_uns),
    .rm_i   (cv_rm),
    .res_o  (cv_res),
    .inv_o  (cv_inv),
    .inx_o  (cv_inx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_last    <= 1'b0;
      out_undef   <= 1'b0;
      out_invalid <= '0;
      out_inexact <= '0;
      pend_q      <= 1'b0;
      pend_op_q   <= '0;
      pend_size_q <= SZ_S32;
      pend_uns_q  <= 1'b0;
      pend_rm_q   <= RM_NEAR_AWAY;
    end else if (slot_free) begin
      if (pend_q) begin
        out_valid   <= 1'b1;
        out_data    <= cv_res;
        out_invalid <= cv_inv;
        out_inexact <= cv_inx;
        out_last    <= 1'b1;
        out_undef   <= 1'b0;
        pend_q      <= 1'b0;
      end else if (take) begin
        out_valid <= 1'b1;
        if (undef) begin
          out_data    <= '0;
          out_invalid <= '0;
          out_inexact <= '0;
          out_last    <= 1'b1;
          out_undef   <= 1'b1;
        end else begin
          out_data    <= cv_res;
          out_invalid <= cv_inv;
          out_inexact <= cv_inx;
          out_last    <= !in_quad;
          out_undef   <= 1'b0;
          pend_q      <= in_quad;
          pend_op_q   <= in_data[127:WORD_W];
          pend_size_q <= esize_e'(in_size);
          pend_uns_q  <= in_unsigned;
          pend_rm_q   <= rmode_e'(in_rmode);
        end
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  p_undef_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_undef) |->
      (out_data == '0 && out_last && out_invalid == '0 && out_inexact == '0));

  p_bad_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_size == 2'b00 || in_size == 2'b11)) |=>
      (out_valid && out_undef));

  p_odd_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_quad && (in_src_lsb || in_dst_lsb)) |=>
      (out_valid && out_undef));

  p_quad_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_last && !out_undef));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_invalid)));
endmodule

// File: tb/simd_f2i_conv_tb.sv
`timescale 1ns/1ps
module simd_f2i_conv_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [1:0]   in_size = 2'b10;
  logic         in_unsigned = 1'b0;
  logic [1:0]   in_rmode = 2'b00;
  logic         in_quad = 1'b0;
  logic         in_src_lsb = 1'b0;
  logic         in_dst_lsb = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [63:0]  out_data;
  logic         out_last, out_undef;
  logic [3:0]   out_invalid, out_inexact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  simd_f2i_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_size(in_size), .in_unsigned(in_unsigned),
    .in_rmode(in_rmode), .in_quad(in_quad), .in_src_lsb(in_src_lsb),
    .in_dst_lsb(in_dst_lsb), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .out_undef(out_undef),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic send(logic [127:0] d, logic [1:0] sz, logic u, logic [1:0] rm,
                      logic q, logic sl, logic dl);
    @(negedge clk);
    in_data = d; in_size = sz; in_unsigned = u; in_rmode = rm;
    in_quad = q; in_src_lsb = sl; in_dst_lsb = dl; in_valid = 1'b1;
    chk("R10", "in_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic beat(string rq, logic [63:0] d, logic [3:0] iv, logic [3:0] ix,
                      logic lst, logic ud);
    chk(rq, "out_valid", 64'(out_valid), 64'd1);
    chk(rq, "out_data", out_data, d);
    chk(rq, "out_invalid", 64'(out_invalid), 64'(iv));
    chk(rq, "out_inexact", 64'(out_inexact), 64'(ix));
    chk(rq, "out_last", 64'(out_last), 64'(lst));
    chk(rq, "out_undef", 64'(out_undef), 64'(ud));
    @(negedge clk);
  endtask

  // Half lanes {L3,L2,L1,L0} = {0.5, -2.5, 2.5, 1.5}
  localparam logic [63:0] HALF_TIES = {16'h3800, 16'hC100, 16'h4100, 16'h3E00};

  task automatic t_reset();
    chk("R10", "reset out_valid", 64'(out_valid), 64'd0);
    chk("R10", "reset in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_half_rounding();
    send({64'd0, HALF_TIES}, 2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    beat("R4 away", 64'h0001_FFFD_0003_0002, 4'h0, 4'hF, 1'b1, 1'b0);
    send({64'd0, HALF_TIES}, 2'b01, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
    beat("R4 even", 64'h0000_FFFE_0002_0002, 4'h0, 4'hF, 1'b1, 1'b0);
    send({64'd0, HALF_TIES}, 2'b01, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0);
    beat("R4 up", 64'h0001_FFFE_0003_0002, 4'h0, 4'hF, 1'b1, 1'b0);
    send({64'd0, HALF_TIES}, 2'b01, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
    beat("R4 down R1 R5", 64'h0000_FFFD_0002_0001, 4'h0, 4'hF, 1'b1, 1'b0);
  endtask

  task automatic t_half_special();
    // {subnormal, -inf, 65504, NaN}, signed
    send({64'd0, 16'h0001, 16'hFC00, 16'h7BFF, 16'h7E00}, 2'b01, 1'b0, 2'b00,
         1'b0, 1'b0, 1'b0);
    beat("R3 R6", 64'h0000_8000_7FFF_0000, 4'b0111, 4'b0000, 1'b1, 1'b0);
  endtask

  task automatic t_half_unsigned();
    // {3.0, -1.0, -0.25, 65504}, unsigned
    send({64'd0, 16'h4200, 16'hBC00, 16'hB400, 16'h7BFF}, 2'b01, 1'b1, 2'b00,
         1'b0, 1'b0, 1'b0);
    beat("R7 R3", 64'h0003_0000_0000_FFE0, 4'b0100, 4'b0010, 1'b1, 1'b0);
  endtask

  task automatic t_single();
    // {-2^31, 2^31}, signed
    send({64'd0, 32'hCF00_0000, 32'h4F00_0000}, 2'b10, 1'b0, 2'b00,
         1'b0, 1'b0, 1'b0);
    beat("R3 R11", 64'h8000_0000_7FFF_FFFF, 4'b0001, 4'b0000, 1'b1, 1'b0);
    // {2.5, 2^32}, unsigned, ties to even
    send({64'd0, 32'h4020_0000, 32'h4F80_0000}, 2'b10, 1'b1, 2'b01,
         1'b0, 1'b0, 1'b0);
    beat("R3 R4 R11", 64'h0000_0002_FFFF_FFFF, 4'b0001, 4'b0010, 1'b1, 1'b0);
    // {0.5, -0}, signed
    send({64'd0, 32'h3F00_0000, 32'h8000_0000}, 2'b10, 1'b0, 2'b00,
         1'b0, 1'b0, 1'b0);
    beat("R6 R5 R1", 64'h0000_0001_0000_0000, 4'b0000, 4'b0010, 1'b1, 1'b0);
  endtask

  task automatic t_bad_size();
    send({64'd0, HALF_TIES}, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    beat("R2 size00", 64'd0, 4'h0, 4'h0, 1'b1, 1'b1);
    send({64'd0, HALF_TIES}, 2'b11, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
    beat("R2 size11", 64'd0, 4'h0, 4'h0, 1'b1, 1'b1);
    chk("R2", "no second beat", 64'(out_valid), 64'd0);
  endtask

  localparam logic [127:0] QUAD_OP = {32'h3F00_0000, 32'hC020_0000,
                                      32'h4020_0000, 32'h3FC0_0000};

  task automatic t_quad();
    send(QUAD_OP, 2'b10, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
    beat("R8 low", 64'h0000_0003_0000_0002, 4'h0, 4'b0011, 1'b0, 1'b0);
    beat("R8 high", 64'h0000_0001_FFFF_FFFD, 4'h0, 4'b0011, 1'b1, 1'b0);
    chk("R8", "idle after quad", 64'(out_valid), 64'd0);
  endtask

  task automatic t_quad_odd();
    send(QUAD_OP, 2'b10, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
    beat("R9 src", 64'd0, 4'h0, 4'h0, 1'b1, 1'b1);
    chk("R9", "no tail src", 64'(out_valid), 64'd0);
    send(QUAD_OP, 2'b10, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1);
    beat("R9 dst", 64'd0, 4'h0, 4'h0, 1'b1, 1'b1);
    chk("R9", "no tail dst", 64'(out_valid), 64'd0);
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    send(QUAD_OP, 2'b10, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      chk("R10", "held valid", 64'(out_valid), 64'd1);
      chk("R10", "held data", out_data, 64'h0000_0003_0000_0002);
      chk("R10", "held last", 64'(out_last), 64'd0);
      chk("R10", "in_ready low", 64'(in_ready), 64'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8", "tail data", out_data, 64'h0000_0001_FFFF_FFFD);
    chk("R8", "tail last", 64'(out_last), 64'd1);
    chk("R10", "ready after tail", 64'(in_ready), 64'd1);
    @(negedge clk);
    chk("R10", "drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_half_rounding();
    t_half_special();
    t_half_unsigned();
    t_single();
    t_bad_size();
    t_quad();
    t_quad_odd();
    t_backpressure();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule